// File: doc/BRIEF.md
# Memory-Fetching Sample Playback Channel

This block adds a direct-memory sample player to an audio register block. While an extension flag is set in audio register 0x30, writes to three of the standard sample registers are taken over. One register sets a start address. One sets a byte count. One starts or stops playback. A rate counter then paces one memory read for every period of CPU cycles. Each fetched byte is halved and sent to a 7-bit DAC level output. The last byte of a run stops the channel and raises an interrupt. That interrupt also appears in the top bit of the status read.

Every register write is passed on to the standard channel logic one cycle later. While the extension is active, a control write has its enable bit removed before it is forwarded, so the standard sample engine never starts. With the extension clear, the three registers act as plain storage and the channel state is left alone.

Top module: `dma_pcm_channel`

## Requirements
- R1: After reset, irq, mem_req and dac_wr are low, dac_level is 0 and status_out equals status_in.
- R2: While bit 4 of register 0x30 is clear, writes to 0x12, 0x13 and 0x15 start no fetch and leave irq unchanged, and status_out equals status_in.
- R3: With the extension set, a write of v to register 0x12 makes the next run start reading at address v*64.
- R4: With the extension set, a write of v to register 0x13 makes a run fetch exactly 16*v+1 bytes.
- R5: With the extension set, a write to 0x15 takes the channel enable from bit 4. Enabling reloads the rate counter to the period (default 246). The first DAC write of a run appears 248 clock edges after the enabling write's edge. Disabling stops any further fetch.
- R6: During a run, DAC writes come every 247 cycles. Each carries the fetched byte shifted right by one, and the read address rises by one per byte.
- R7: After the last byte of a run, irq is high and no further memory request is made.
- R8: With the extension set, any write to 0x15 clears irq on the next edge.
- R9: With the extension set, status_out bit 7 equals irq and bits 6:0 equal status_in.
- R10: Every register write is repeated on fwd_wr, fwd_addr and fwd_wdata one cycle later. The data is unchanged, except that a write to 0x15 with the extension set has bit 4 cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst | input | 1 | synchronous active-high reset |
| reg_wr | input | 1 | audio register write strobe |
| reg_addr | input | 6 | register offset within the 64-entry audio window |
| reg_wdata | input | 8 | register write data |
| status_in | input | 8 | status byte from the standard channel logic |
| status_out | output | 8 | status byte returned to the CPU |
| fwd_wr | output | 1 | forwarded write strobe to standard channel logic |
| fwd_addr | output | 6 | forwarded register offset |
| fwd_wdata | output | 8 | forwarded (possibly masked) data |
| mem_req | output | 1 | memory read request, held until mem_valid |
| mem_addr | output | 15 | memory read address |
| mem_valid | input | 1 | memory read data valid |
| mem_rdata | input | 8 | memory read data |
| dac_wr | output | 1 | one-cycle DAC update strobe |
| dac_level | output | 7 | halved sample value |
| irq | output | 1 | sample run complete interrupt |

## Verification
A forwarded write is due one edge after its source write. A control write clears irq on that same edge. With a one-cycle memory, the first DAC write of a run is due 248 edges after the enabling edge, and each following one 247 edges after the one before. The bench counts posedges in a free-running counter and samples everything on the falling edge. It keeps the edge of each enabling write and the edge of each DAC strobe, and compares their differences with those counts. A scoreboard queue holds the expected addresses and halved values of each run. The memory model and the DAC monitor pop it in order, so a missing, extra or misplaced fetch shows up as a mismatch or as a queue that is not empty.

// File: rtl/dma_pcm_pkg.sv
package dma_pcm_pkg;
  localparam int REG_AW   = 6;
  localparam logic [REG_AW-1:0] OFF_START = 6'h12;
  localparam logic [REG_AW-1:0] OFF_COUNT = 6'h13;
  localparam logic [REG_AW-1:0] OFF_CTRL  = 6'h15;
  localparam logic [REG_AW-1:0] OFF_EXT   = 6'h30;
  localparam int EXT_BIT = 4;
  localparam int RUN_BIT = 4;
  localparam int IRQ_BIT = 7;
endpackage

// File: rtl/dma_pcm_regif.sv
module dma_pcm_regif
  import dma_pcm_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [DATA_W-1:0] status_in,
  input  logic              irq_flag,
  output logic [DATA_W-1:0] status_out,
  output logic              fwd_wr,
  output logic [REG_AW-1:0] fwd_addr,
  output logic [DATA_W-1:0] fwd_wdata,
  output logic              ext_on,
  output logic              set_start,
  output logic              set_count,
  output logic              set_ctrl
);
  logic              ext_q;
  logic [DATA_W-1:0] fwd_data_d;

  always_comb begin
    set_start  = reg_wr && ext_q && (reg_addr == OFF_START);
    set_count  = reg_wr && ext_q && (reg_addr == OFF_COUNT);
    set_ctrl   = reg_wr && ext_q && (reg_addr == OFF_CTRL);
    fwd_data_d = reg_wdata;
    if (set_ctrl) fwd_data_d[RUN_BIT] = 1'b0;
    status_out = status_in;
    if (ext_q) status_out[IRQ_BIT] = irq_flag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ext_q     <= 1'b0;
      fwd_wr    <= 1'b0;
      fwd_addr  <= '0;
      fwd_wdata <= '0;
    end else begin
      if (reg_wr && reg_addr == OFF_EXT) ext_q <= reg_wdata[EXT_BIT];
      fwd_wr <= reg_wr;
      if (reg_wr) begin
        fwd_addr  <= reg_addr;
        fwd_wdata <= fwd_data_d;
      end
    end
  end

  assign ext_on = ext_q;
endmodule

// File: rtl/dma_pcm_rate.sv
module dma_pcm_rate #(
  parameter int               CNT_W  = 8,
  parameter logic [CNT_W-1:0] PERIOD = 8'hF6
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic run,
  output logic tick
);
  logic [CNT_W-1:0] cnt_q;

  assign tick = run && !load && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= PERIOD;
    end else if (load) begin
      cnt_q <= PERIOD;
    end else if (run) begin
      cnt_q <= (cnt_q == '0) ? PERIOD : cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/dma_pcm_fetch.sv
module dma_pcm_fetch #(
  parameter int DATA_W     = 8,
  parameter int ADDR_W     = 15,
  parameter int ADDR_SHIFT = 6,
  parameter int LEN_SHIFT  = 4,
  parameter int RUN_BIT    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] wdata,
  input  logic              set_start,
  input  logic              set_count,
  input  logic              set_ctrl,
  input  logic              tick,
  output logic              running,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_valid,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              dac_wr,
  output logic [DATA_W-2:0] dac_level,
  output logic              irq
);
  localparam int LEN_W = DATA_W + LEN_SHIFT + 1;

  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  len_q;
  logic              unused_lsb;

  assign unused_lsb = mem_rdata[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q    <= '0;
      len_q     <= '0;
      running   <= 1'b0;
      mem_req   <= 1'b0;
      mem_addr  <= '0;
      dac_wr    <= 1'b0;
      dac_level <= '0;
      irq       <= 1'b0;
    end else begin
      dac_wr <= 1'b0;
      if (set_start) addr_q <= ADDR_W'(wdata) << ADDR_SHIFT;
      if (set_count) len_q  <= (LEN_W'(wdata) << LEN_SHIFT) + LEN_W'(1);
      if (set_ctrl) begin
        running <= wdata[RUN_BIT];
        irq     <= 1'b0;
      end
      if (tick && !mem_req) begin
        mem_req  <= 1'b1;
        mem_addr <= addr_q;
      end
      if (mem_req && mem_valid) begin
        mem_req   <= 1'b0;
        dac_wr    <= 1'b1;
        dac_level <= mem_rdata[DATA_W-1:1];
        addr_q    <= addr_q + 1'b1;
        if (len_q < LEN_W'(2)) begin
          len_q   <= '0;
          running <= 1'b0;
          irq     <= 1'b1;
        end else begin
          len_q <= len_q - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dma_pcm_channel.sv
module dma_pcm_channel
  import dma_pcm_pkg::*;
#(
  parameter int               DATA_W     = 8,
  parameter int               ADDR_W     = 15,
  parameter int               ADDR_SHIFT = 6,
  parameter int               LEN_SHIFT  = 4,
  parameter int               CNT_W      = 8,
  parameter logic [CNT_W-1:0] PERIOD     = 8'hF6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [5:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  input  logic [7:0]        status_in,
  output logic [7:0]        status_out,
  output logic              fwd_wr,
  output logic [5:0]        fwd_addr,
  output logic [7:0]        fwd_wdata,
  output logic              mem_req,
  output logic [14:0]       mem_addr,
  input  logic              mem_valid,
  input  logic [7:0]        mem_rdata,
  output logic              dac_wr,
  output logic [6:0]        dac_level,
  output logic              irq
);
  logic ext_on, set_start, set_count, set_ctrl, tick, running, rate_load;

  assign rate_load = set_ctrl && reg_wdata[RUN_BIT];

  dma_pcm_regif #(.DATA_W(DATA_W)) u_regif (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .status_in(status_in), .irq_flag(irq),
    .status_out(status_out), .fwd_wr(fwd_wr), .fwd_addr(fwd_addr),
    .fwd_wdata(fwd_wdata), .ext_on(ext_on), .set_start(set_start),
    .set_count(set_count), .set_ctrl(set_ctrl)
  );

  dma_pcm_rate #(.CNT_W(CNT_W), .PERIOD(PERIOD)) u_rate (
    .clk(clk), .rst(rst), .load(rate_load), .run(running), .tick(tick)
  );

  dma_pcm_fetch #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .ADDR_SHIFT(ADDR_SHIFT),
    .LEN_SHIFT(LEN_SHIFT), .RUN_BIT(RUN_BIT)
  ) u_fetch (
    .clk(clk), .rst(rst), .wdata(reg_wdata), .set_start(set_start),
    .set_count(set_count), .set_ctrl(set_ctrl), .tick(tick),
    .running(running), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_valid(mem_valid), .mem_rdata(mem_rdata), .dac_wr(dac_wr),
    .dac_level(dac_level), .irq(irq)
  );
endmodule

// File: rtl/dma_pcm_channel_chk.sv
module dma_pcm_channel_chk (
  input logic        clk,
  input logic        rst,
  input logic        reg_wr,
  input logic [5:0]  reg_addr,
  input logic [7:0]  reg_wdata,
  input logic [7:0]  status_in,
  input logic [7:0]  status_out,
  input logic        fwd_wr,
  input logic [5:0]  fwd_addr,
  input logic        mem_req,
  input logic [14:0] mem_addr,
  input logic        mem_valid,
  input logic        dac_wr,
  input logic        irq,
  input logic        ext_on
);
  // R7: interrupt only rises together with the final DAC update
  a_r7_irq_with_last_byte: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> dac_wr);

  // R6: an open request keeps its address until answered
  a_r6_req_held: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));

  // R6: a DAC update closes the request that produced it
  a_r6_dac_after_req: assert property (@(posedge clk) disable iff (rst)
    dac_wr |-> (!mem_req && $past(mem_req)));

  // R8: control write with extension set drops the interrupt
  a_r8_irq_clear: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && ext_on && reg_addr == 6'h15) |=> !irq);

  // R10: each write reappears one cycle later
  a_r10_forward: assert property (@(posedge clk) disable iff (rst)
    reg_wr |=> (fwd_wr && fwd_addr == $past(reg_addr)));

  // R2: without the extension, status passes through untouched
  a_r2_status_pass: assert property (@(posedge clk) disable iff (rst)
    !ext_on |-> (status_out == status_in));

  // R9: low status bits always come from the standard logic
  a_r9_low_bits: assert property (@(posedge clk) disable iff (rst)
    status_out[6:0] == status_in[6:0]);

  logic unused_wdata;
  assign unused_wdata = ^reg_wdata;
endmodule

bind dma_pcm_channel dma_pcm_channel_chk u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .status_in(status_in), .status_out(status_out),
  .fwd_wr(fwd_wr), .fwd_addr(fwd_addr), .mem_req(mem_req),
  .mem_addr(mem_addr), .mem_valid(mem_valid), .dac_wr(dac_wr),
  .irq(irq), .ext_on(ext_on)
);

// File: tb/dma_pcm_channel_tb.sv
module dma_pcm_channel_tb;
  localparam int P = 246;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  status_in = '0;
  logic [7:0]  status_out;
  logic        fwd_wr;
  logic [5:0]  fwd_addr;
  logic [7:0]  fwd_wdata;
  logic        mem_req;
  logic [14:0] mem_addr;
  logic        mem_valid = 1'b0;
  logic [7:0]  mem_rdata = '0;
  logic        dac_wr;
  logic [6:0]  dac_level;
  logic        irq;

  int checks = 0, fails = 0;
  int cyc = 0, first_cyc = 0, prev_cyc = 0;
  int n_req = 0, n_dac = 0;
  bit first_pending = 0;
  logic [14:0] exp_addr[$];
  logic [6:0]  exp_val[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dma_pcm_channel u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .status_in(status_in), .status_out(status_out),
    .fwd_wr(fwd_wr), .fwd_addr(fwd_addr), .fwd_wdata(fwd_wdata),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid),
    .mem_rdata(mem_rdata), .dac_wr(dac_wr), .dac_level(dac_level), .irq(irq)
  );

  function automatic logic [7:0] mem_byte(input logic [14:0] a);
    return a[7:0] ^ 8'hA5;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // memory model: one-cycle response, compares address with scoreboard
  always @(negedge clk) begin
    if (mem_req && !mem_valid) begin
      n_req++;
      checks++;
      if (exp_addr.size() == 0) begin
        fails++;
        $display("FAIL R7: actual request at %0h expected none", mem_addr);
      end else begin
        logic [14:0] ea;
        ea = exp_addr.pop_front();
        if (mem_addr != ea) begin
          fails++;
          $display("FAIL R3: actual address %0h expected %0h", mem_addr, ea);
        end
      end
      mem_rdata = mem_byte(mem_addr);
      mem_valid = 1'b1;
    end else begin
      mem_valid = 1'b0;
    end
  end

  // DAC monitor: value, first latency, spacing
  always @(negedge clk) begin
    if (!rst && dac_wr) begin
      n_dac++;
      checks++;
      if (exp_val.size() == 0) begin
        fails++;
        $display("FAIL R6: actual dac %0h expected none", dac_level);
      end else begin
        logic [6:0] ev;
        ev = exp_val.pop_front();
        if (dac_level != ev) begin
          fails++;
          $display("FAIL R6: actual dac %0h expected %0h", dac_level, ev);
        end
      end
      if (first_pending) begin
        check("R5 first latency", cyc - first_cyc, P + 2);
        first_pending = 0;
      end else if (prev_cyc != 0) begin
        check("R6 spacing", cyc - prev_cyc, P + 1);
      end
      prev_cyc = cyc;
    end
  end

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic start_run(input logic [14:0] base, input int nbytes, input logic [7:0] ctl);
    for (int i = 0; i < nbytes; i++) begin
      logic [14:0] a;
      logic [7:0]  b;
      a = base + 15'(i);
      b = mem_byte(a);
      exp_addr.push_back(a);
      exp_val.push_back(b[7:1]);
    end
    prev_cyc = 0;
    wr(6'h15, ctl);
    first_cyc = cyc;
    first_pending = 1;
  endtask

  task automatic wait_irq(input int limit);
    for (int i = 0; i < limit && !irq; i++) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int base_req, base_dac;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    status_in = 8'h80;
    @(negedge clk);
    // R1 reset state
    check("R1 irq", irq, 0);
    check("R1 mem_req", mem_req, 0);
    check("R1 dac_wr", dac_wr, 0);
    check("R1 dac_level", dac_level, 0);
    check("R1 status", status_out, 8'h80);

    // R2 extension off: no takeover
    wr(6'h12, 8'h10);
    wr(6'h13, 8'h05);
    wr(6'h15, 8'h10);
    check("R10 plain forward data", fwd_wdata, 8'h10);
    check("R10 plain forward addr", fwd_addr, 6'h15);
    base_req = n_req;
    repeat (600) @(negedge clk);
    check("R2 no fetch", n_req, base_req);
    check("R2 irq", irq, 0);
    check("R2 status", status_out, 8'h80);

    // extension on, 17-byte run at 0x0840
    wr(6'h30, 8'h10);
    status_in = 8'h00;
    wr(6'h12, 8'h21);
    wr(6'h13, 8'h01);
    base_dac = n_dac;
    start_run(15'h0840, 17, 8'h1F);
    check("R10 masked forward", fwd_wdata, 8'h0F);
    wait_irq(6000);
    @(negedge clk);
    check("R4 byte count", n_dac - base_dac, 17);
    check("R7 irq set", irq, 1);
    check("R9 status irq bit", status_out, 8'h80);
    status_in = 8'h7F;
    @(negedge clk);
    check("R9 status mix", status_out, 8'hFF);
    status_in = 8'h00;
    base_req = n_req;
    repeat (600) @(negedge clk);
    check("R7 no more fetch", n_req, base_req);
    check("R6 queue drained", exp_val.size(), 0);

    // R8 clear interrupt
    wr(6'h15, 8'h00);
    check("R8 irq cleared", irq, 0);
    check("R9 status after clear", status_out, 8'h00);

    // one-byte run at 0x3FC0
    wr(6'h12, 8'hFF);
    wr(6'h13, 8'h00);
    base_dac = n_dac;
    start_run(15'h3FC0, 1, 8'h10);
    wait_irq(2000);
    @(negedge clk);
    check("R4 single byte", n_dac - base_dac, 1);
    check("R7 irq single", irq, 1);

    // R5 disable before first fetch
    wr(6'h13, 8'h02);
    prev_cyc = 0;
    wr(6'h15, 8'h10);
    base_req = n_req;
    repeat (100) @(negedge clk);
    wr(6'h15, 8'h00);
    repeat (600) @(negedge clk);
    check("R5 disable stops fetch", n_req, base_req);
    check("R5 irq stays clear", irq, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule